// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This peripheral holds a parameterised number of identical 32-bit timer channels behind a small word-addressed register bus. Each channel decrements once per tick of a clock source chosen from a set of tick-enable inputs, after a power-of-two prescaler. A channel runs either periodically, reloading its interval on each expiry, or in one-shot mode, stopping at zero. When software requests it, a channel copies its interval into the counter. Each expiry sets a per-channel pending flag in a shared status register. A single interrupt line is asserted while any pending flag has its bit set in the shared enable register.

Software starts a channel by writing the interval and then writing the control word with both the run and load bits set. The count register can be read at any time. Software can take the bit-inverted count as a free-running up-counter, and an interval of all ones gives the longest period. Stopping a channel is not immediate: after the run bit is cleared, the channel keeps counting for a fixed number of raw ticks of its selected source before it halts. Software must allow for that delay before it reprograms the channel.

Top module: `mctimer`

## Requirements
- R1: After reset every register reads as zero, `bus_rdata` is zero and `irq_o` is low.
- R2: The register map uses word-aligned byte addresses. The interrupt-enable register is at 0x00. The status register is at 0x04. Channel n has its control register at 0x10+0x10·n, its interval register at 0x14+0x10·n and its count register at 0x18+0x10·n. Every other address reads zero, and so does any access with address bits 1:0 non-zero. Writes to a count register are ignored. Read data appears on `bus_rdata` in the cycle after the read request.
- R3: Control bits are: bit 0 run, bit 1 load, bits 3:2 source select, bits 6:4 prescaler exponent, bit 7 one-shot (1) or periodic (0). A write with both run and load set copies the interval into the count and starts the channel. The load bit always reads back as 0.
- R4: A running channel decrements its count by one per prescaled tick of the source selected by bits 3:2, where source k is `src_tick[k]`. Ticks on the other sources have no effect on the count.
- R5: With prescaler exponent p, the count moves once per 2^p ticks of the selected source, counted from the most recent load. The first move comes on tick 2^p.
- R6: Expiry is a decrement step taken from count 1. It sets that channel's status bit (bit n) whether or not the channel's interrupt is enabled. In periodic mode the same step puts the interval value into the count.
- R7: In one-shot mode an expiry leaves the count at 0, stops the channel and clears the run bit as read back. Later ticks leave the count at 0.
- R8: Writing 1 to a status bit clears it, and writing 0 to a status bit leaves it unchanged.
- R9: `irq_o` is high exactly when some channel has both its status bit and its enable bit (bit n of 0x00) set. It updates on the same clock edge as those registers.
- R10: After a write that clears the run bit of a running channel, the channel goes on counting for DIS_TICKS (default 2) further ticks of its selected raw source and then holds its count.
- R11: An interval of 0xFFFFFFFF loads as 0xFFFFFFFF, and the next step gives 0xFFFFFFFE. The inverted count therefore reads as a 32-bit up-counter starting at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | CW (32) | Write data |
| bus_rdata | output | CW (32) | Registered read data, valid the cycle after a read |
| src_tick | input | 4 | Tick enables of the selectable clock sources |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench goes after the disable delay. A channel that halted at once would hold its count one or two steps too early, and one that ignored the delay limit would keep counting. It drives the unselected sources to catch a source multiplexer wired to the wrong input, and it checks the first prescaled step, where an off-by-one divider would fire early or late. At the one-shot and periodic expiries it checks that the count lands at 0 or at the interval rather than wrapping, and that the status bit is set while the interrupt stays masked. It also covers write-one-to-clear, with a write of the wrong bit that must leave the flag set, and the all-ones interval, where a design that truncated the load would show a short period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PRE_W = 3;
  localparam int SRC_W = 2;
  localparam int NSRC  = 1 << SRC_W;

  typedef struct packed {
    logic             oneshot;
    logic [PRE_W-1:0] pre;
    logic [SRC_W-1:0] src;
    logic             rld;
    logic             en;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  typedef enum logic [1:0] {
    CH_CTRL = 2'd0,
    CH_IVL  = 2'd1,
    CH_CNT  = 2'd2,
    CH_RSV  = 2'd3
  } ch_word_e;

  localparam logic [1:0] GW_IEN = 2'd0;
  localparam logic [1:0] GW_STS = 2'd1;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick_in,
  input  logic [PRE_W-1:0] pre,
  output logic             tick_out
);
  localparam int PCW = (1 << PRE_W) - 1;

  logic [PCW-1:0] div_q;
  logic [PCW-1:0] mask;

  // low 'pre' bits set: the step fires when all of them are ones
  always_comb begin
    mask = '0;
    for (int b = 0; b < PCW; b++) begin
      if (b < int'(pre)) mask[b] = 1'b1;
    end
  end

  assign tick_out = tick_in & ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else if (tick_in) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW        = 32,
  parameter int DIS_TICKS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_tick,
  input  logic            wr_ctrl,
  input  logic            wr_ivl,
  input  logic [CW-1:0]   wdata,
  output tmr_ctrl_t       ctrl_o,
  output logic [CW-1:0]   ivl_o,
  output logic [CW-1:0]   cnt_o,
  output logic            run_o,
  output logic            expire_o,
  output logic            load_o
);
  localparam int SCW = (DIS_TICKS < 2) ? 1 : $clog2(DIS_TICKS + 1);

  tmr_ctrl_t       ctrl_q, wctrl, wctrl_st;
  logic [CW-1:0]   ivl_q, cnt_q;
  logic            run_q, stop_pend_q;
  logic [SCW-1:0]  stop_cnt_q;
  logic            raw_tick, step, load, expire, stop_now;

  assign wctrl    = tmr_ctrl_t'(wdata[CTRL_W-1:0]);
  assign load     = wr_ctrl & wctrl.rld;
  assign raw_tick = src_tick[ctrl_q.src];

  // the load bit is an action, never stored
  always_comb begin
    wctrl_st     = wctrl;
    wctrl_st.rld = 1'b0;
  end

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .clr      (load),
    .tick_in  (raw_tick),
    .pre      (ctrl_q.pre),
    .tick_out (step)
  );

  assign expire   = run_q & step & ~load & (cnt_q == CW'(1));
  assign stop_now = stop_pend_q & raw_tick & (stop_cnt_q == SCW'(DIS_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      ivl_q       <= '0;
      cnt_q       <= '0;
      run_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      stop_cnt_q  <= '0;
    end else begin
      if (wr_ivl) ivl_q <= wdata;

      // pending disable: count raw source ticks, then halt
      if (stop_pend_q && raw_tick) begin
        if (stop_now) begin
          run_q       <= 1'b0;
          stop_pend_q <= 1'b0;
        end else begin
          stop_cnt_q <= stop_cnt_q + 1'b1;
        end
      end

      if (load) begin
        cnt_q <= ivl_q;
      end else if (run_q && step) begin
        if (expire) begin
          if (ctrl_q.oneshot) begin
            cnt_q       <= '0;
            run_q       <= 1'b0;
            ctrl_q.en   <= 1'b0;
            stop_pend_q <= 1'b0;
          end else begin
            cnt_q <= ivl_q;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      // a register write overrides the same-cycle state updates
      if (wr_ctrl) begin
        ctrl_q <= wctrl_st;
        if (wctrl.en) begin
          run_q       <= 1'b1;
          stop_pend_q <= 1'b0;
        end else if (run_q && !stop_pend_q) begin
          stop_pend_q <= 1'b1;
          stop_cnt_q  <= '0;
        end
      end
    end
  end

  assign ctrl_o   = ctrl_q;
  assign ivl_o    = ivl_q;
  assign cnt_o    = cnt_q;
  assign run_o    = run_q;
  assign expire_o = expire;
  assign load_o   = load;
endmodule

// File: rtl/tmr_irq_bank.sv
module tmr_irq_bank #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_ien,
  input  logic           wr_sts,
  input  logic [NCH-1:0] wbits,
  input  logic [NCH-1:0] expire,
  output logic [NCH-1:0] ien_o,
  output logic [NCH-1:0] sts_o,
  output logic           irq_o
);
  logic [NCH-1:0] ien_q, sts_q, ien_n, sts_n, clr;

  always_comb begin
    clr   = wr_sts ? wbits : '0;
    sts_n = (sts_q & ~clr) | expire;  // a new expiry wins over a clear
    ien_n = wr_ien ? wbits : ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= '0;
      sts_q <= '0;
      irq_o <= 1'b0;
    end else begin
      ien_q <= ien_n;
      sts_q <= sts_n;
      irq_o <= |(sts_n & ien_n);
    end
  end

  assign ien_o = ien_q;
  assign sts_o = sts_q;
endmodule

// File: rtl/mctimer.sv
module mctimer
  import tmr_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int CW        = 32,
  parameter int AW        = 8,
  parameter int DIS_TICKS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [CW-1:0]   bus_wdata,
  output logic [CW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_tick,
  output logic            irq_o
);
  localparam int WIN_W = AW - 4;

  logic [WIN_W-1:0] win;
  logic [1:0]       word;
  logic             aligned, wr_en, rd_en, glob_hit;
  logic [CW-1:0]    rd_nxt;

  logic [NCH-1:0]         ch_hit, wctl_a, wivl_a;
  logic [NCH-1:0]         run_a, exp_a, load_a, oneshot_a;
  logic [NCH-1:0][CW-1:0] ivl_a, cnt_a;
  tmr_ctrl_t              ctrl_a [NCH];
  logic [NCH-1:0]         ien_w, sts_w;

  assign win      = bus_addr[AW-1:4];
  assign word     = bus_addr[3:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wr_en    = bus_sel & bus_wr;
  assign rd_en    = bus_sel & ~bus_wr;
  assign glob_hit = aligned & (win == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_hit[g]    = aligned & (win == WIN_W'(g + 1));
    assign wctl_a[g]    = wr_en & ch_hit[g] & (word == CH_CTRL);
    assign wivl_a[g]    = wr_en & ch_hit[g] & (word == CH_IVL);
    assign oneshot_a[g] = ctrl_a[g].oneshot;

    tmr_channel #(.CW(CW), .DIS_TICKS(DIS_TICKS)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .src_tick (src_tick),
      .wr_ctrl  (wctl_a[g]),
      .wr_ivl   (wivl_a[g]),
      .wdata    (bus_wdata),
      .ctrl_o   (ctrl_a[g]),
      .ivl_o    (ivl_a[g]),
      .cnt_o    (cnt_a[g]),
      .run_o    (run_a[g]),
      .expire_o (exp_a[g]),
      .load_o   (load_a[g])
    );
  end

  tmr_irq_bank #(.NCH(NCH)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .wr_ien (wr_en & glob_hit & (word == GW_IEN)),
    .wr_sts (wr_en & glob_hit & (word == GW_STS)),
    .wbits  (bus_wdata[NCH-1:0]),
    .expire (exp_a),
    .ien_o  (ien_w),
    .sts_o  (sts_w),
    .irq_o  (irq_o)
  );

  always_comb begin
    rd_nxt = '0;
    if (glob_hit) begin
      if (word == GW_IEN)      rd_nxt[NCH-1:0] = ien_w;
      else if (word == GW_STS) rd_nxt[NCH-1:0] = sts_w;
    end
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit[i]) begin
        case (ch_word_e'(word))
          CH_CTRL: rd_nxt[CTRL_W-1:0] = ctrl_a[i];
          CH_IVL:  rd_nxt = ivl_a[i];
          CH_CNT:  rd_nxt = cnt_a[i];
          default: rd_nxt = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_nxt;
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int NCH = 2,
  parameter int CW  = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   irq_o,
  input logic [NCH-1:0]         sts_q,
  input logic [NCH-1:0]         ien_q,
  input logic [NCH-1:0][CW-1:0] cnt_a,
  input logic [NCH-1:0][CW-1:0] ivl_a,
  input logic [NCH-1:0]         run_a,
  input logic [NCH-1:0]         exp_a,
  input logic [NCH-1:0]         load_a,
  input logic [NCH-1:0]         oneshot_a,
  input logic [NCH-1:0]         wctl_a
);
  // R9: interrupt line tracks the masked pending flags
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(sts_q & ien_q));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R6/R8: a status bit only rises after that channel expired
    a_r6_sts_needs_expiry: assert property (@(posedge clk) disable iff (rst)
      $rose(sts_q[g]) |-> $past(exp_a[g]));

    // R6: periodic expiry reloads the interval
    a_r6_periodic_reload: assert property (@(posedge clk) disable iff (rst)
      exp_a[g] && !oneshot_a[g] |=> cnt_a[g] == $past(ivl_a[g]));

    // R7: one-shot expiry halts at zero
    a_r7_oneshot_halt: assert property (@(posedge clk) disable iff (rst)
      exp_a[g] && oneshot_a[g] && !wctl_a[g] |=> !run_a[g] && cnt_a[g] == '0);

    // R4: outside load and expiry the count holds or steps down by one
    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
      !load_a[g] && !exp_a[g] |=>
        (cnt_a[g] == $past(cnt_a[g])) || (cnt_a[g] == CW'($past(cnt_a[g]) - 1'b1)));
  end
endmodule

bind mctimer tmr_checker #(.NCH(NCH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_o     (irq_o),
  .sts_q     (sts_w),
  .ien_q     (ien_w),
  .cnt_a     (cnt_a),
  .ivl_a     (ivl_a),
  .run_a     (run_a),
  .exp_a     (exp_a),
  .load_a    (load_a),
  .oneshot_a (oneshot_a),
  .wctl_a    (wctl_a)
);

// File: tb/test_mctimer.sv
module test_mctimer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = '0;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sbq[$];
  logic rd_seen_q = 1'b0;

  localparam logic [7:0] A_IEN = 8'h00, A_STS = 8'h04;
  localparam logic [7:0] A_CTL0 = 8'h10, A_IVL0 = 8'h14, A_CNT0 = 8'h18;
  localparam logic [7:0] A_CTL1 = 8'h20, A_IVL1 = 8'h24, A_CNT1 = 8'h28;

  always #10 clk = ~clk;

  mctimer i_mctimer (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_tick  (src_tick),
    .irq_o     (irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // driver: issues the read and queues the expected data
  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp;
    it.tag = tag;
    @(negedge clk);
    sbq.push_back(it);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic tick(input int src, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      src_tick[src] = 1'b1;
      @(negedge clk);
      src_tick = '0;
    end
  endtask

  // monitor: compares read data the cycle after each request
  always @(posedge clk) rd_seen_q <= bus_sel & ~bus_wr & ~rst;

  always @(negedge clk) begin
    if (rd_seen_q) begin
      if (sbq.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R2 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        rd_item_t it;
        it = sbq.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    bus_read(A_CTL0, 32'h0, "R1 ctrl0 reset");
    bus_read(A_IVL1, 32'h0, "R1 ivl1 reset");
    bus_read(A_CNT0, 32'h0, "R1 cnt0 reset");
    bus_read(A_IEN,  32'h0, "R1 ien reset");
    bus_read(A_STS,  32'h0, "R1 sts reset");

    // R3 run+load on channel 0, source 1, no prescale, periodic
    bus_write(A_IVL0, 32'd5);
    bus_write(A_CTL0, 32'h07);
    bus_read(A_CNT0, 32'd5, "R3 load copies interval");
    bus_read(A_CTL0, 32'h05, "R3 load bit reads 0");

    // R4 stepping and source selection
    tick(1, 3);
    bus_read(A_CNT0, 32'd2, "R4 three steps");
    tick(0, 2);
    tick(2, 1);
    tick(3, 1);
    bus_read(A_CNT0, 32'd2, "R4 other sources ignored");

    // R6 periodic expiry with interrupt masked
    tick(1, 2);
    bus_read(A_CNT0, 32'd5, "R6 periodic reload");
    bus_read(A_STS, 32'h1, "R6 status set on expiry");
    check("R9 masked irq stays low", {31'b0, irq_o}, 32'h0);

    // R9 / R8 enable and write-one-to-clear
    bus_write(A_IEN, 32'h1);
    check("R9 irq on enable", {31'b0, irq_o}, 32'h1);
    bus_write(A_STS, 32'h2);
    bus_read(A_STS, 32'h1, "R8 zero write keeps flag");
    bus_write(A_STS, 32'h1);
    bus_read(A_STS, 32'h0, "R8 one write clears flag");
    check("R9 irq drops on clear", {31'b0, irq_o}, 32'h0);

    // R10 disable delay on channel 0 (count is 5)
    bus_write(A_CTL0, 32'h04);
    bus_read(A_CTL0, 32'h04, "R10 run bit reads 0");
    tick(1, 1);
    bus_read(A_CNT0, 32'd4, "R10 counts first delay tick");
    tick(1, 1);
    bus_read(A_CNT0, 32'd3, "R10 counts second delay tick");
    tick(1, 3);
    bus_read(A_CNT0, 32'd3, "R10 halted after delay");
    // R2 count write ignored, misaligned and unmapped reads
    bus_write(A_CNT0, 32'h1234);
    bus_read(A_CNT0, 32'd3, "R2 count write ignored");
    bus_read(8'h19, 32'h0, "R2 misaligned read zero");
    bus_read(8'h1C, 32'h0, "R2 reserved word zero");
    bus_read(8'h30, 32'h0, "R2 unmapped window zero");
    bus_write(A_IEN, 32'h0);

    // R5 prescaler 2^2 and R7 one-shot on channel 1
    bus_write(A_IVL1, 32'd3);
    bus_write(A_CTL1, 32'hA7);
    bus_read(A_CNT1, 32'd3, "R5 loaded");
    tick(1, 3);
    bus_read(A_CNT1, 32'd3, "R5 no step before tick 4");
    tick(1, 1);
    bus_read(A_CNT1, 32'd2, "R5 step on tick 4");
    tick(1, 4);
    bus_read(A_CNT1, 32'd1, "R5 step on tick 8");
    tick(1, 4);
    bus_read(A_CNT1, 32'd0, "R7 one-shot ends at zero");
    bus_read(A_STS, 32'h2, "R6 channel 1 status bit");
    bus_read(A_CTL1, 32'hA4, "R7 run bit cleared");
    check("R9 irq masked for ch1", {31'b0, irq_o}, 32'h0);
    tick(1, 8);
    bus_read(A_CNT1, 32'd0, "R7 stays at zero");
    bus_write(A_STS, 32'h2);
    bus_read(A_STS, 32'h0, "R8 clear ch1 flag");

    // R11 full-width interval
    bus_write(A_IVL1, 32'hFFFF_FFFF);
    bus_write(A_CTL1, 32'h07);
    bus_read(A_CNT1, 32'hFFFF_FFFF, "R11 all-ones load");
    tick(1, 1);
    bus_read(A_CNT1, 32'hFFFF_FFFE, "R11 first step");

    // R9 / R6 channel 1 interrupt path
    bus_write(A_IEN, 32'h2);
    bus_write(A_IVL1, 32'd2);
    bus_write(A_CTL1, 32'h07);
    tick(1, 2);
    check("R9 irq from ch1", {31'b0, irq_o}, 32'h1);
    bus_read(A_CNT1, 32'd2, "R6 ch1 periodic reload");
    bus_read(A_IEN, 32'h2, "R2 enable readback");

    repeat (3) @(negedge clk);
    check("R2 all reads answered", sbq.size(), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule